// File: doc/BRIEF.md
# Fracturable LUT Evaluation Unit

This block is the purely combinational core of one programmable logic element. It looks up a 64-bit configuration word using eight physical input pins and drives a top-half result and a bottom-half result. A 2-bit mode field picks one of three uses of the word.

- In the single 6-input mode the whole word is one function.
- In the dual 5-input mode each half of the word is an independent 5-input function, and the two functions share two inputs.
- In the arithmetic mode each half holds two 4-input sub-tables. These feed a full-adder stage, and the carry ripples from the top half into the bottom half.

Both the stored word and the pins work in inverted polarity. The word holds the complement of the intended truth table, and each pin is complemented before it takes part in the table index. Elements of this kind are chained: the carry output of one element feeds the carry input of the next. The block has no registers, no routing muxes and no configuration loading logic.

Top module: `flut_eval`

## Requirements
- R1: The stored word is the complement of the truth table, and every index bit is the complement of its pin. An output reads `~cfg_word[idx]`, where idx is built from the complemented pins.
- R2: Pin A always drives index bit 0 and pin B always drives index bit 1, in every mode and in both halves.
- R3: With mode 00 (dual 5-input), out_top reads word bits 0..31 at index {~F0,~E0,~C,~B,~A}, with bit 4 on the left.
- R4: With mode 00, out_bot reads word bits 32..63 at offset {~F1,~E1,~D,~B,~A}. Pins C, E0 and F0 never change out_bot.
- R5: With mode 01 (6-input), out_top reads the word at an index built as follows. Bit 5 is ~E0 and bit 4 is ~F0. When bit 5 is 0, bit 3 is ~D and bit 2 is ~C. When bit 5 is 1, bit 3 is ~C and bit 2 is ~D.
- R6: With mode 01, out_bot is 0 and carry_out is 0, whatever the pins are.
- R7: With mode 10 (arithmetic), the top half has a lower sub-table at bits {~E0,~C,~B,~A} and an upper sub-table at 16+{~F0,~C,~B,~A}. The bottom half has a lower sub-table at 32+{~E1,~D,~B,~A} and an upper sub-table at 48+{~F1,~D,~B,~A}.
- R8: With mode 10, each half outputs lower XOR upper XOR its carry-in. The majority of those three values is that half's carry-out. carry_in enters the top half, the top carry-out feeds the bottom half, and the bottom carry-out is carry_out.
- R9: With mode 00, carry_out is 0. With mode 11, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_word | input | 64 | Complemented truth table |
| cfg_mode | input | 2 | 00 dual 5-input, 01 6-input, 10 arithmetic, 11 idle |
| pin_a | input | 1 | Shared input, index bit 0 |
| pin_b | input | 1 | Shared input, index bit 1 |
| pin_c | input | 1 | Top-half input |
| pin_d | input | 1 | Bottom-half input |
| pin_e0 | input | 1 | Top-half input |
| pin_e1 | input | 1 | Bottom-half input |
| pin_f0 | input | 1 | Top-half input |
| pin_f1 | input | 1 | Bottom-half input |
| carry_in | input | 1 | Carry into the top half |
| out_top | output | 1 | Top-half result (the sum in arithmetic mode) |
| out_bot | output | 1 | Bottom-half result (the sum in arithmetic mode) |
| carry_out | output | 1 | Carry out of the bottom half |

## Verification
The hardest case to reach is the 6-input mode, where C and D swap index positions. That swap is visible only when the word differs between addresses that differ in bits 2 and 3 on both sides of the bit-5 boundary. A second hard case is the carry rippling through both halves, which needs the top sub-tables to propagate while the bottom sub-tables generate, or the reverse.

The bench runs pseudo-random configuration words in every mode and sweeps all 512 combinations of the eight pins and carry_in for each word. This hits every address and every propagate/generate pairing. Directed single-bit words then pin down polarity, the A/B positions and the C/D swap.

// File: rtl/flut_pkg.sv
package flut_pkg;

    localparam int LUT_K   = 6;
    localparam int TABLE_W = 1 << LUT_K;
    localparam int HALF_W  = TABLE_W / 2;
    localparam int SUB_W   = HALF_W / 2;
    localparam int ADDR_W  = LUT_K;
    localparam int N_RD    = 4;

    // read-port slots
    localparam int RD_TOP_LO = 0;
    localparam int RD_TOP_HI = 1;
    localparam int RD_BOT_LO = 2;
    localparam int RD_BOT_HI = 3;

    typedef enum logic [1:0] {
        MODE_DUAL5 = 2'b00,
        MODE_LUT6  = 2'b01,
        MODE_ARITH = 2'b10,
        MODE_IDLE  = 2'b11
    } flut_mode_e;

    typedef struct packed {
        logic f1;
        logic f0;
        logic e1;
        logic e0;
        logic d;
        logic c;
        logic b;
        logic a;
    } flut_pins_t;

    typedef logic [ADDR_W-1:0] flut_addr_t;

    typedef struct packed {
        logic top;
        logic bot;
        logic cout;
    } flut_result_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/flut_pin_map.sv
module flut_pin_map
    import flut_pkg::*;
#(
    parameter int NRD = N_RD,
    parameter int AW  = ADDR_W
) (
    input  flut_mode_e               mode_i,
    input  flut_pins_t               pins_i,
    output logic [NRD-1:0][AW-1:0]   addr_o
);

    flut_pins_t s;

    always_comb begin
        s      = ~pins_i;
        addr_o = '0;
        unique case (mode_i)
            MODE_DUAL5: begin
                addr_o[RD_TOP_LO] = {1'b0, s.f0, s.e0, s.c, s.b, s.a};
                addr_o[RD_TOP_HI] = {1'b0, s.f0, s.e0, s.c, s.b, s.a};
                addr_o[RD_BOT_LO] = {1'b1, s.f1, s.e1, s.d, s.b, s.a};
                addr_o[RD_BOT_HI] = {1'b1, s.f1, s.e1, s.d, s.b, s.a};
            end
            MODE_LUT6: begin
                // C and D trade index positions across the bit-5 boundary
                if (s.e0)
                    addr_o[RD_TOP_LO] = {1'b1, s.f0, s.c, s.d, s.b, s.a};
                else
                    addr_o[RD_TOP_LO] = {1'b0, s.f0, s.d, s.c, s.b, s.a};
                addr_o[RD_TOP_HI] = addr_o[RD_TOP_LO];
                addr_o[RD_BOT_LO] = addr_o[RD_TOP_LO];
                addr_o[RD_BOT_HI] = addr_o[RD_TOP_LO];
            end
            MODE_ARITH: begin
                addr_o[RD_TOP_LO] = {2'b00, s.e0, s.c, s.b, s.a};
                addr_o[RD_TOP_HI] = {2'b01, s.f0, s.c, s.b, s.a};
                addr_o[RD_BOT_LO] = {2'b10, s.e1, s.d, s.b, s.a};
                addr_o[RD_BOT_HI] = {2'b11, s.f1, s.d, s.b, s.a};
            end
            default: addr_o = '0;
        endcase
    end

    // The two halves never read each other's table region.
    always_comb begin
        if (mode_i == MODE_DUAL5 || mode_i == MODE_ARITH) begin
            assert_half_split_R3: assert (!addr_o[RD_TOP_LO][AW-1] && addr_o[RD_BOT_LO][AW-1])
                else $error("top/bottom address regions overlap");
        end
    end

    // Shared pins land on index bits 0 and 1 for every active read.
    always_comb begin
        if (mode_i != MODE_IDLE) begin
            assert_shared_pins_R2: assert (addr_o[RD_TOP_LO][1:0] == addr_o[RD_BOT_HI][1:0])
                else $error("shared index bits differ between halves");
        end
    end

endmodule

// File: rtl/flut_table_read.sv
module flut_table_read
    import flut_pkg::*;
#(
    parameter int NRD = N_RD,
    parameter int AW  = ADDR_W,
    parameter int TW  = TABLE_W
) (
    input  logic [TW-1:0]           cfg_i,
    input  logic [NRD-1:0][AW-1:0]  addr_i,
    output logic [NRD-1:0]          bit_o
);

    genvar k;
    generate
        for (k = 0; k < NRD; k++) begin : g_rd
            // stored word is the complement of the truth table
            assign bit_o[k] = ~cfg_i[addr_i[k]];
        end
    endgenerate

endmodule

// File: rtl/flut_carry_half.sv
module flut_carry_half
    import flut_pkg::*;
(
    input  logic lo_i,
    input  logic hi_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);

    assign sum_o  = lo_i ^ hi_i ^ cin_i;
    assign cout_o = maj3(lo_i, hi_i, cin_i);

    // generate/kill when the operands agree, propagate otherwise
    always_comb begin
        if (lo_i == hi_i) begin
            assert_gen_kill_R8: assert (cout_o == lo_i && sum_o == cin_i)
                else $error("carry generate/kill wrong");
        end else begin
            assert_propagate_R8: assert (cout_o == cin_i && sum_o == !cin_i)
                else $error("carry propagate wrong");
        end
    end

endmodule

// File: rtl/flut_eval.sv
module flut_eval
    import flut_pkg::*;
#(
    parameter int TW  = TABLE_W,
    parameter int AW  = ADDR_W,
    parameter int NRD = N_RD
) (
    input  logic [TW-1:0] cfg_word,
    input  logic [1:0]    cfg_mode,
    input  logic          pin_a,
    input  logic          pin_b,
    input  logic          pin_c,
    input  logic          pin_d,
    input  logic          pin_e0,
    input  logic          pin_e1,
    input  logic          pin_f0,
    input  logic          pin_f1,
    input  logic          carry_in,
    output logic          out_top,
    output logic          out_bot,
    output logic          carry_out
);

    localparam int N_HALF = 2;

    flut_mode_e                 mode;
    flut_pins_t                 pins;
    logic [NRD-1:0][AW-1:0]     addr;
    logic [NRD-1:0]             rd_bit;
    logic [N_HALF:0]            chain;
    logic [N_HALF-1:0]          sum;
    flut_result_t               res;

    assign mode = flut_mode_e'(cfg_mode);
    assign pins = '{f1: pin_f1, f0: pin_f0, e1: pin_e1, e0: pin_e0,
                    d: pin_d, c: pin_c, b: pin_b, a: pin_a};

    flut_pin_map #(.NRD(NRD), .AW(AW)) u_map (
        .mode_i (mode),
        .pins_i (pins),
        .addr_o (addr)
    );

    flut_table_read #(.NRD(NRD), .AW(AW), .TW(TW)) u_read (
        .cfg_i  (cfg_word),
        .addr_i (addr),
        .bit_o  (rd_bit)
    );

    assign chain[0] = carry_in;

    genvar h;
    generate
        for (h = 0; h < N_HALF; h++) begin : g_half
            flut_carry_half u_fa (
                .lo_i   (rd_bit[2*h]),
                .hi_i   (rd_bit[2*h+1]),
                .cin_i  (chain[h]),
                .sum_o  (sum[h]),
                .cout_o (chain[h+1])
            );
        end
    endgenerate

    always_comb begin
        res = '0;
        unique case (mode)
            MODE_DUAL5: begin
                res.top = rd_bit[RD_TOP_LO];
                res.bot = rd_bit[RD_BOT_LO];
            end
            MODE_LUT6:  res.top = rd_bit[RD_TOP_LO];
            MODE_ARITH: begin
                res.top  = sum[0];
                res.bot  = sum[1];
                res.cout = chain[N_HALF];
            end
            default: res = '0;
        endcase
    end

    assign out_top   = res.top;
    assign out_bot   = res.bot;
    assign carry_out = res.cout;

    always_comb begin
        if (mode == MODE_LUT6) begin
            assert_lut6_bot_quiet_R6: assert (!out_bot && !carry_out)
                else $error("bottom half active in 6-input mode");
        end
        if (mode == MODE_IDLE) begin
            assert_idle_quiet_R9: assert (!out_top && !out_bot && !carry_out)
                else $error("outputs active in idle mode");
        end
        if (mode == MODE_DUAL5) begin
            assert_dual5_no_carry_R9: assert (!carry_out)
                else $error("carry_out active in dual mode");
        end
    end

endmodule

// File: tb/flut_eval_bench.sv
module flut_eval_bench;

    logic        clk = 1'b0;
    logic [63:0] cfg_word;
    logic [1:0]  cfg_mode;
    logic        pin_a, pin_b, pin_c, pin_d, pin_e0, pin_e1, pin_f0, pin_f1;
    logic        carry_in;
    logic        out_top, out_bot, carry_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    flut_eval u_flut_eval (
        .cfg_word (cfg_word), .cfg_mode (cfg_mode),
        .pin_a (pin_a), .pin_b (pin_b), .pin_c (pin_c), .pin_d (pin_d),
        .pin_e0 (pin_e0), .pin_e1 (pin_e1), .pin_f0 (pin_f0), .pin_f1 (pin_f1),
        .carry_in (carry_in),
        .out_top (out_top), .out_bot (out_bot), .carry_out (carry_out)
    );

    function automatic logic [63:0] next_word(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    function automatic int bitof(input logic [7:0] v, input int i);
        return v[i] ? 1 : 0;
    endfunction

    // reference: returns {top, bot, cout}; p = {f1,f0,e1,e0,d,c,b,a}
    function automatic logic [2:0] ref_eval(input logic [63:0] w, input logic [1:0] m,
                                            input logic [7:0] p, input logic ci);
        logic [63:0] t;
        logic [7:0]  x;
        int idx, lo_t, hi_t, lo_b, hi_b;
        logic tl, th, bl, bh, st, ct, sb, cb;
        t = ~w;
        x = ~p;
        case (m)
            2'b00: begin
                idx  = bitof(x,0) + 2*bitof(x,1) + 4*bitof(x,2) + 8*bitof(x,4) + 16*bitof(x,6);
                lo_b = 32 + bitof(x,0) + 2*bitof(x,1) + 4*bitof(x,3) + 8*bitof(x,5) + 16*bitof(x,7);
                return {t[idx], t[lo_b], 1'b0};
            end
            2'b01: begin
                if (x[4])
                    idx = 32 + 16*bitof(x,6) + 8*bitof(x,2) + 4*bitof(x,3) + 2*bitof(x,1) + bitof(x,0);
                else
                    idx = 16*bitof(x,6) + 8*bitof(x,3) + 4*bitof(x,2) + 2*bitof(x,1) + bitof(x,0);
                return {t[idx], 1'b0, 1'b0};
            end
            2'b10: begin
                lo_t = bitof(x,0) + 2*bitof(x,1) + 4*bitof(x,2) + 8*bitof(x,4);
                hi_t = 16 + bitof(x,0) + 2*bitof(x,1) + 4*bitof(x,2) + 8*bitof(x,6);
                lo_b = 32 + bitof(x,0) + 2*bitof(x,1) + 4*bitof(x,3) + 8*bitof(x,5);
                hi_b = 48 + bitof(x,0) + 2*bitof(x,1) + 4*bitof(x,3) + 8*bitof(x,7);
                tl = t[lo_t]; th = t[hi_t]; bl = t[lo_b]; bh = t[hi_b];
                st = tl ^ th ^ ci;
                ct = (int'(tl) + int'(th) + int'(ci)) >= 2;
                sb = bl ^ bh ^ ct;
                cb = (int'(bl) + int'(bh) + int'(ct)) >= 2;
                return {st, sb, cb};
            end
            default: return 3'b000;
        endcase
    endfunction

    task automatic drive(input logic [63:0] w, input logic [1:0] m,
                         input logic [7:0] p, input logic ci);
        @(negedge clk);
        cfg_word = w; cfg_mode = m; carry_in = ci;
        {pin_f1, pin_f0, pin_e1, pin_e0, pin_d, pin_c, pin_b, pin_a} = p;
        #2;
    endtask

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s mode=%b cfg=%h pins=%b cin=%b actual=%b expected=%b",
                     req, cfg_mode, cfg_word, {pin_f1, pin_f0, pin_e1, pin_e0, pin_d, pin_c, pin_b, pin_a},
                     carry_in, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R3/R4 dual";
            2'b01:   return "R5/R6 six-input";
            2'b10:   return "R7/R8 arith";
            default: return "R9 idle";
        endcase
    endfunction

    initial begin
        logic [63:0] w;
        // all-zero quiescent state: idle mode, everything low
        drive(64'h0, 2'b11, 8'h00, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b000, "R9 idle at start");

        // R1: word 0 means truth all ones
        drive(64'h0, 2'b00, 8'h00, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b110, "R1 zero word");
        // R1: bit 0 stored high, all pins high -> index 0 -> output 0
        drive(64'h1, 2'b00, 8'hFF, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b010, "R1 bit0 polarity");
        // R2: only A low -> index 1
        drive(64'h2, 2'b00, 8'hFE, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b010, "R2 A is bit0");
        // R2: only B low -> index 2, bit 1 not selected
        drive(64'h2, 2'b00, 8'hFD, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b110, "R2 B is bit1");
        // R5: bit 36 = upper half with D on bit 2; E0=0 D=0, others high
        drive(64'h1 << 36, 2'b01, 8'b1110_0111 & ~8'b0000_1000, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b000, "R5 C/D swap upper");
        // R5: same word, C low instead of D -> index 40, not stored
        drive(64'h1 << 36, 2'b01, 8'b1110_1011, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b100, "R5 C/D swap upper alt");
        // R5: lower half bit 8 = D on bit 3 when E0 high
        drive(64'h1 << 8, 2'b01, 8'b1111_0111, 1'b0);
        check({out_top, out_bot, carry_out}, 3'b000, "R5 D on bit3 lower");
        // R8: word 0, arith: all sub-tables 1 -> sum = cin, carry 1
        drive(64'h0, 2'b10, 8'h00, 1'b1);
        check({out_top, out_bot, carry_out}, 3'b111, "R8 all generate");
        // R8: all ones word: sub-tables 0 -> kill, cin shows on top only
        drive({64{1'b1}}, 2'b10, 8'h00, 1'b1);
        check({out_top, out_bot, carry_out}, 3'b100, "R8 all kill");

        // sweeps: 4 words per mode, all pins and carry_in
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                rng = next_word(rng);
                w = rng;
                for (int v = 0; v < 512; v++) begin
                    drive(w, 2'(m), v[7:0], v[8]);
                    check({out_top, out_bot, carry_out},
                          ref_eval(w, 2'(m), v[7:0], v[8]), mode_req(2'(m)));
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not complete actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule